// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This block sits beside a processor bus and watches every bus cycle. When a cycle meets the programmed conditions, it raises a break request. Each of the two channels compares the bus address against a compare value under a mask. A channel can also require a given address-space identifier (ASID) and selects which kind of bus cycle it reacts to. Channel 1 adds a masked compare on the bus data and an execution counter, so that only the N-th qualifying match produces a break.

The two channels work in one of two modes. In independent mode, either channel raises a break on its own. In sequential mode, a channel-0 match only arms the unit, and a channel-1 match in a later cycle then produces one break. A small register-write port loads the settings. A sticky status register records which source caused each break, and a write of ones clears it.

Top module: `hw_brk_unit`

## Requirements
- R1: After reset, `brk_req` is 0, `brk_status` is 0, both channels are disabled, and no bus cycle produces a break.
- R2: A channel's address condition holds when `((bus_addr ^ compare) & ~mask) == 0`. A mask of zero compares every bit. A set mask bit removes that bit from the compare.
- R3: When control bit 3 (ASID enable) is set, the condition also needs `bus_asid` equal to control bits [15:8]. When the bit is clear, the ASID is ignored.
- R4: Control bits [2:1] select the cycle kind: 0 = fetch, 1 = read, 2 = write, 3 = read or write. `bus_kind` is encoded 0 = fetch, 1 = read, 2 = write, and 3 matches nothing. A fetch condition whose compare address is odd never matches. Control bit 0 enables the channel.
- R5: When channel-1 control bit 4 is set, channel 1 also needs `((bus_data ^ dcmp) & ~dmask) == 0`. When the bit is clear, the data is ignored.
- R6: In independent mode (mode bit 0 = 0), a channel-0 match breaks and sets status bit 0. A channel-1 match breaks and sets status bit 1. The two channels do not affect each other.
- R7: In sequential mode, a channel-0 match arms the unit. A channel-1 match while armed breaks and sets status bit 2. A channel-1 match while not armed, including one in the same cycle as the arming channel-0 match, does nothing.
- R8: The armed state clears when the sequential break is raised, when the mode register is written, and on reset.
- R9: When channel-1 control bit 5 is set and the count is non-zero, each qualifying channel-1 match decrements the count. Only the match that finds the count at 1 breaks, and that match leaves the count at 0. A count of 0 disables counting, so every later match breaks. A write to the count register takes priority over a decrement in the same cycle.
- R10: `brk_req` is high in the single cycle after a matching bus cycle. Consecutive matching cycles give consecutive pulses.
- R11: Writing ones to the status register clears those bits. A break in the same cycle sets its bit regardless of the clear.
- R12: Register selects: 0 ch0 compare, 1 ch0 mask, 2 ch0 control, 3 ch1 compare, 4 ch1 mask, 5 ch1 control, 6 ch1 data compare, 7 ch1 data mask, 8 ch1 count, 9 mode, 10 status. A write takes effect for bus cycles from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Bus cycle present |
| bus_kind | input | 2 | Cycle kind: fetch, read, write |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| bus_asid | input | 8 | Address-space identifier of the cycle |
| brk_req | output | 1 | Break request pulse |
| brk_status | output | 3 | Sticky break source: ch0, ch1, sequence |

## Verification
A corrupted armed flag shows at the ports as a sequential break that comes too early or never comes. It becomes visible at the first channel-1 match after the fault. A wrong count value shifts the break pulse by one or more qualifying matches. Because every break also sets a status bit, a wrong source shows in `brk_status` in the same cycle as the pulse, and the mismatch stays visible until software clears the bit.

// File: rtl/hw_brk_unit.sv
module hw_brk_unit #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8,
  parameter int CW  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_sel,
  input  logic [((AW > DW) ? AW : DW)-1:0] cfg_wdata,
  input  logic                 bus_valid,
  input  logic [1:0]           bus_kind,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_data,
  input  logic [IDW-1:0]       bus_asid,
  output logic                 brk_req,
  output logic [2:0]           brk_status
);

  localparam int CTLW = 8 + IDW;
  localparam logic [1:0] K_FETCH = 2'd0, K_READ = 2'd1, K_WRITE = 2'd2, K_DATA = 2'd3;
  localparam logic [3:0] S_C0A = 4'd0, S_C0M = 4'd1, S_C0C = 4'd2, S_C1A = 4'd3,
                         S_C1M = 4'd4, S_C1C = 4'd5, S_C1D = 4'd6, S_C1DM = 4'd7,
                         S_CNT = 4'd8, S_MODE = 4'd9, S_STAT = 4'd10;

  logic [AW-1:0]   c0_addr, c0_mask, c1_addr, c1_mask;
  logic [DW-1:0]   c1_data, c1_dmask;
  logic [CTLW-1:0] c0_ctl, c1_ctl;
  logic [CW-1:0]   cnt_q;
  logic            seq_q, armed_q, brk_q;
  logic [2:0]      status_q;

  function automatic logic kind_ok(input logic [1:0] sel, input logic [1:0] k);
    if (sel == K_DATA) return (k == K_READ) || (k == K_WRITE);
    return k == sel;
  endfunction

  function automatic logic chan_hit(input logic [AW-1:0] ca, input logic [AW-1:0] cm,
                                    input logic [CTLW-1:0] cc, input logic [AW-1:0] a,
                                    input logic [IDW-1:0] id, input logic [1:0] k);
    logic odd_fetch;
    odd_fetch = (cc[2:1] == K_FETCH) && ca[0];
    return cc[0] && kind_ok(cc[2:1], k) && !odd_fetch &&
           (((a ^ ca) & ~cm) == '0) && (!cc[3] || (id == cc[8 +: IDW]));
  endfunction

  logic m0, m1, q1, cnt_on, hit0, hit1, wr_mode, wr_cnt, wr_stat;
  logic [2:0] sets, clr;

  assign m0 = bus_valid && chan_hit(c0_addr, c0_mask, c0_ctl, bus_addr, bus_asid, bus_kind);
  assign m1 = bus_valid && chan_hit(c1_addr, c1_mask, c1_ctl, bus_addr, bus_asid, bus_kind) &&
              (!c1_ctl[4] || (((bus_data ^ c1_data) & ~c1_dmask) == '0));
  assign q1     = m1 && (!seq_q || armed_q);
  assign cnt_on = c1_ctl[5] && (cnt_q != '0);
  assign hit1   = q1 && (!cnt_on || (cnt_q == CW'(1)));
  assign hit0   = m0 && !seq_q;
  assign sets   = {seq_q && hit1, !seq_q && hit1, hit0};

  assign wr_mode = cfg_we && (cfg_sel == S_MODE);
  assign wr_cnt  = cfg_we && (cfg_sel == S_CNT);
  assign wr_stat = cfg_we && (cfg_sel == S_STAT);
  assign clr     = wr_stat ? cfg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_addr <= '0; c0_mask <= '0; c0_ctl <= '0;
      c1_addr <= '0; c1_mask <= '0; c1_ctl <= '0;
      c1_data <= '0; c1_dmask <= '0;
      seq_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        S_C0A:  c0_addr  <= cfg_wdata[AW-1:0];
        S_C0M:  c0_mask  <= cfg_wdata[AW-1:0];
        S_C0C:  c0_ctl   <= cfg_wdata[CTLW-1:0];
        S_C1A:  c1_addr  <= cfg_wdata[AW-1:0];
        S_C1M:  c1_mask  <= cfg_wdata[AW-1:0];
        S_C1C:  c1_ctl   <= cfg_wdata[CTLW-1:0];
        S_C1D:  c1_data  <= cfg_wdata[DW-1:0];
        S_C1DM: c1_dmask <= cfg_wdata[DW-1:0];
        S_MODE: seq_q    <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      status_q <= '0;
      brk_q    <= 1'b0;
    end else begin
      if (wr_cnt)            cnt_q <= cfg_wdata[CW-1:0];
      else if (q1 && cnt_on) cnt_q <= cnt_q - CW'(1);
      if (wr_mode)           armed_q <= 1'b0;
      else if (seq_q) begin
        if (hit1)            armed_q <= 1'b0;
        else if (m0)         armed_q <= 1'b1;
      end
      status_q <= (status_q & ~clr) | sets;
      brk_q    <= hit0 || hit1;
    end
  end

  assign brk_req    = brk_q;
  assign brk_status = status_q;

  // R8
  armed_only_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> seq_q);

  // R7
  seq_brk_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && $past(seq_q)) |-> $past(armed_q));

  // R10
  brk_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> (status_q != 3'b000));

  // R11
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && cfg_wdata[0] && !hit0) |=> !status_q[0]);

  // R4
  odd_fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ctl[2:1] == K_FETCH && c0_addr[0] && !status_q[0] && !cfg_we) |=> !status_q[0]);

endmodule

// File: tb/tb_hw_brk_unit.sv
module tb_hw_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_kind = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [7:0]  bus_asid = '0;
  logic        brk_req;
  logic [2:0]  brk_status;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hw_brk_unit dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_asid(bus_asid), .brk_req(brk_req), .brk_status(brk_status));

  logic [31:0] m_c0a, m_c0m, m_c1a, m_c1m, m_c1d, m_c1dm;
  logic [15:0] m_c0c, m_c1c;
  logic [11:0] m_cnt;
  logic        m_seq, m_arm;
  logic [2:0]  m_st;
  logic        e_brk;

  function automatic bit chan(bit v, logic [31:0] a, logic [7:0] id, logic [1:0] k,
                              logic [31:0] ca, logic [31:0] cm, logic [15:0] cc);
    bit kok;
    kok = (cc[2:1] == 2'd3) ? (k == 2'd1 || k == 2'd2) : (k == cc[2:1]);
    return v && cc[0] && kok && !(cc[2:1] == 2'd0 && ca[0]) &&
           (((a ^ ca) & ~cm) == 0) && (!cc[3] || id == cc[15:8]);
  endfunction

  task automatic model_reset();
    m_c0a = 0; m_c0m = 0; m_c1a = 0; m_c1m = 0; m_c1d = 0; m_c1dm = 0;
    m_c0c = 0; m_c1c = 0; m_cnt = 0; m_seq = 0; m_arm = 0; m_st = 0; e_brk = 0;
  endtask

  task automatic model_step(bit we, logic [3:0] sel, logic [31:0] wd, bit v,
                            logic [31:0] a, logic [31:0] d, logic [7:0] id, logic [1:0] k);
    bit mt0, mt1, q1, con, h0, h1, narm;
    logic [11:0] ncnt;
    logic [2:0] sets, clr;
    mt0 = chan(v, a, id, k, m_c0a, m_c0m, m_c0c);
    mt1 = chan(v, a, id, k, m_c1a, m_c1m, m_c1c) && (!m_c1c[4] || ((d ^ m_c1d) & ~m_c1dm) == 0);
    q1 = mt1 && (!m_seq || m_arm);
    con = m_c1c[5] && m_cnt != 0;
    h1 = q1 && (!con || m_cnt == 1);
    h0 = mt0 && !m_seq;
    e_brk = h0 || h1;
    sets = {m_seq && h1, !m_seq && h1, h0};
    ncnt = (q1 && con) ? m_cnt - 12'd1 : m_cnt;
    narm = m_seq ? (h1 ? 1'b0 : (mt0 ? 1'b1 : m_arm)) : m_arm;
    clr = 0;
    if (we) case (sel)
      4'd0: m_c0a = wd;  4'd1: m_c0m = wd;  4'd2: m_c0c = wd[15:0];
      4'd3: m_c1a = wd;  4'd4: m_c1m = wd;  4'd5: m_c1c = wd[15:0];
      4'd6: m_c1d = wd;  4'd7: m_c1dm = wd; 4'd8: ncnt = wd[11:0];
      4'd9: begin m_seq = wd[0]; narm = 0; end
      4'd10: clr = wd[2:0];
      default: ;
    endcase
    m_cnt = ncnt; m_arm = narm;
    m_st = (m_st & ~clr) | sets;
  endtask

  task automatic check(string tag);
    total++;
    if (brk_req !== e_brk || brk_status !== m_st) begin
      bad++;
      $display("FAIL %s: brk=%b status=%b expected brk=%b status=%b", tag, brk_req, brk_status, e_brk, m_st);
    end
  endtask

  task automatic step(bit we, logic [3:0] sel, logic [31:0] wd, bit v, logic [31:0] a,
                      logic [31:0] d, logic [7:0] id, logic [1:0] k, string tag);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    bus_valid = v; bus_addr = a; bus_data = d; bus_asid = id; bus_kind = k;
    model_step(we, sel, wd, v, a, d, id, k);
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic w(logic [3:0] sel, logic [31:0] wd, string tag);
    step(1, sel, wd, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic b(logic [31:0] a, logic [31:0] d, logic [7:0] id, logic [1:0] k, string tag);
    step(0, 0, 0, 1, a, d, id, k, tag);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; check("R1 reset state");
    b(32'h0, 32'h0, 8'h0, 2'd0, "R1 disabled fetch");
    b(32'h0, 32'h0, 8'h0, 2'd2, "R1 disabled write");

    // R6 / R2 independent channel 0
    w(0, 32'h1000, "R12"); w(2, 32'h01, "R12");
    b(32'h1000, 0, 0, 0, "R6 ch0 hit");
    b(32'h1004, 0, 0, 0, "R2 mismatch");
    w(1, 32'hF, "R12");
    b(32'h100C, 0, 0, 0, "R2 masked hit");
    b(32'h1010, 0, 0, 0, "R10 idle after hit");
    w(10, 32'h7, "R11 clear");
    // R3 ASID
    w(1, 0, "R12"); w(2, 32'h8009, "R12");
    b(32'h1000, 0, 8'h70, 0, "R3 asid mismatch");
    b(32'h1000, 0, 8'h80, 0, "R3 asid match");
    // R4 odd fetch and kind select
    w(3, 32'h3415, "R12"); w(5, 32'h01, "R12");
    b(32'h3415, 0, 0, 0, "R4 odd fetch never");
    w(0, 32'h2000, "R12"); w(2, 32'h05, "R12");
    b(32'h2000, 0, 0, 1, "R4 read vs write sel");
    b(32'h2000, 0, 0, 2, "R4 write hit");
    b(32'h2000, 0, 0, 3, "R4 kind 3 matches nothing");
    // R5 data compare
    w(3, 32'h4000, "R12"); w(5, 32'h17, "R12"); w(6, 32'hAB, "R12"); w(7, 32'hF0, "R12");
    b(32'h4000, 32'h5B, 0, 2, "R5 masked data hit");
    b(32'h4000, 32'h5A, 0, 2, "R5 data miss");
    // R9 counter
    w(5, 32'h37, "R12"); w(8, 3, "R12");
    b(32'h4000, 32'hAB, 0, 1, "R9 count 3");
    b(32'h4000, 32'hAB, 0, 1, "R9 count 2");
    b(32'h4000, 32'hAB, 0, 1, "R9 count 1 breaks");
    b(32'h4000, 32'hAB, 0, 1, "R9 zero breaks every match");
    b(32'h4000, 32'hAB, 0, 1, "R10 consecutive pulse");
    w(5, 32'h17, "R12");
    // R7 sequential
    w(9, 1, "R12"); w(10, 7, "R11");
    b(32'h4000, 32'hAB, 0, 2, "R7 ch1 unarmed silent");
    b(32'h2000, 0, 0, 2, "R7 ch0 arms only");
    b(32'h4000, 32'hAB, 0, 2, "R7 sequence break");
    b(32'h4000, 32'hAB, 0, 2, "R8 cleared after break");
    b(32'h2000, 0, 0, 2, "R8 rearm");
    w(9, 1, "R8 mode write");
    b(32'h4000, 32'hAB, 0, 2, "R8 disarmed by mode write");
    // R11 set wins over clear
    w(9, 0, "R12"); w(10, 7, "R11");
    step(1, 10, 1, 1, 32'h2000, 0, 0, 2, "R11 set beats clear");
    b(32'h0, 0, 0, 1, "R11 stays set");

    // constrained random
    for (int r = 0; r < 24; r++) begin
      logic [31:0] base0, base1, dat;
      base0 = ($urandom & 32'hFFF0) | (($urandom % 8 == 0) ? 1 : 0);
      base1 = ($urandom & 32'hFFF0) | (($urandom % 8 == 0) ? 1 : 0);
      dat = $urandom;
      w(0, base0, "R12"); w(3, base1, "R12");
      w(1, ($urandom % 3 == 0) ? ($urandom & 32'hF) : 0, "R2");
      w(4, ($urandom % 3 == 0) ? ($urandom & 32'hF) : 0, "R2");
      w(2, (($urandom % 2) << 8) | ($urandom & 32'hF) | 1, "R3");
      w(5, (($urandom % 2) << 8) | ($urandom & 32'h3F) | 1, "R9");
      w(6, dat, "R5"); w(7, ($urandom % 2) ? 32'hFF : 0, "R5");
      w(8, $urandom % 5, "R9"); w(9, $urandom % 2, "R7");
      for (int i = 0; i < 250; i++) begin
        int p;
        logic [31:0] a;
        p = $urandom % 3;
        a = (p == 0) ? base0 : (p == 1) ? base1 : $urandom;
        if ($urandom % 4 == 0) a = a ^ ($urandom & 32'h1F);
        if ($urandom % 25 == 0)
          step(1, 10, $urandom & 7, 1, a, dat ^ (($urandom % 2) ? 0 : $urandom), $urandom % 2, $urandom % 4, "R11");
        else if ($urandom % 60 == 0)
          step(1, 9, $urandom % 2, 1, a, dat, $urandom % 2, $urandom % 4, "R8");
        else
          step(0, 0, 0, $urandom % 6 != 0, a, ($urandom % 2) ? dat : $urandom,
               $urandom % 2, $urandom % 4, "R6");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule